// File: doc/BRIEF.md
# IDE Bus-Master DMA Engine

This block moves data for one IDE channel without the processor copying each word. Software fills a table of 8-byte region descriptors in memory. It writes the table's address into a pointer register, picks a direction and sets the run bit. The engine then reads each descriptor over a simple memory request port. It moves 16-bit words between the drive's data stream and the described buffer, and follows the table until the entry flagged as last is finished.

The drive's interrupt line sets the interrupt flag. Clearing the active bit is the engine's own job, and it does so when the table is exhausted. Software can poll the interrupt flag or use the `irq` output, then clear the flag by writing a 1 to it and drop the run bit. A memory error response stops the engine and sets the error flag.

Top module: `ide_bm_dma`

## Requirements
- R1: Registers are selected by `reg_addr`.
  - Offset 0 is the command register: bit 0 is run, bit 3 is direction.
  - Offset 2 is the status register: bit 0 is active, bit 1 is error, bit 2 is interrupt.
  - Offset 4 is the 32-bit table pointer, and its bits 1:0 always read 0.
  - All registers read 0 after reset.
- R2: A write that takes run from 0 to 1 sets active. The engine then reads the table pointer address first and pointer+4 second.
- R3: Each descriptor is two 32-bit memory reads.
  - The first read gives the buffer address, with bit 0 ignored.
  - The second read gives the byte count in bits 15:0, with bit 0 ignored. Bit 31 of the second read is the end-of-table flag.
  - The engine moves one word per memory access, to even addresses that start at the buffer address and rise by 2.
- R4: Direction 1 writes each drive word to memory (`mem_we`=1, `mem_wdata`=`drv_rdata`). Direction 0 reads memory and presents the word on `drv_wdata`.
- R5: After a descriptor without the end flag, the next descriptor is read at the previous descriptor address + 8.
- R6: A byte count of 0 moves 65536 bytes (32768 words).
- R7: When the end-flagged descriptor's last word has moved, active clears and the interrupt flag stays clear. After that no memory request or drive acknowledge occurs, even if the drive still requests.
- R8: A rising edge on `drv_irq` while run is 1 sets the interrupt flag, and `irq` follows the flag. If the drive stops early, active stays 1.
- R9: Writing 1 to status bit 2 or bit 1 clears that flag. Writing 0 changes nothing.
- R10: A command write while active leaves the direction bit unchanged. When the engine is not active, a command write updates it.
- R11: A memory error response sets the error flag and clears active. No further memory request follows.
- R12: Writing run=0 clears active and stops requests. A later start begins again at the table pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request, held until ack or error |
| mem_we | output | 1 | 1 = write word, 0 = read |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 16 | Word written to memory |
| mem_rdata | input | 32 | Read data (descriptor dword or word in bits 15:0) |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Access failed |
| drv_req | input | 1 | Drive requests a data word transfer |
| drv_ack | output | 1 | Engine is serving the drive's request |
| drv_rdata | input | 16 | Word from the drive |
| drv_wdata | output | 16 | Word to the drive, valid with `mem_ack` |
| drv_irq | input | 1 | Drive interrupt line |
| irq | output | 1 | Interrupt flag to the host |

## Verification
The bench sweeps chains of one to three descriptors with several small byte counts in both directions. A wrong step from one descriptor to the next, or a miscounted region, then shows up as a wrong word count or misplaced buffer data. It targets the two ways a transfer can end out of step:
- The drive stops early. A design that cleared active would hide the short transfer.
- The chain runs out while the drive still requests. A design that kept acknowledging would overrun the buffer, and one that raised the interrupt would report completion too soon.

The zero byte count must move a full 64 KiB rather than nothing or a single word. A memory error on the second descriptor read must stop all further fetching. Direction writes during a run must not flip the data path in mid-transfer.

// File: rtl/ide_bm_dma.sv
module ide_bm_dma #(
  parameter int AW = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  input  logic        mem_err,
  input  logic        drv_req,
  output logic        drv_ack,
  input  logic [15:0] drv_rdata,
  output logic [15:0] drv_wdata,
  input  logic        drv_irq,
  output logic        irq
);
  timeunit 1ns; timeprecision 1ps;

  localparam int CW = 17;
  localparam logic [CW-1:0] FULL = CW'(1) << 16;

  typedef enum logic [2:0] {S_IDLE, S_DESC_A, S_DESC_B, S_MOVE, S_DONE} st_t;
  st_t st;

  logic          run, dir, active, err_f, int_f, eot, irq_q;
  logic [AW-1:0] tbl_ptr, cur_ptr, buf_addr;
  logic [CW-1:0] left;

  wire wr_cmd   = reg_wr && reg_addr == 3'd0;
  wire wr_sts   = reg_wr && reg_addr == 3'd2;
  wire wr_ptr   = reg_wr && reg_addr == 3'd4;
  wire go       = wr_cmd && reg_wdata[0] && !run;
  wire halt     = wr_cmd && !reg_wdata[0] && run;
  wire fault    = mem_req && mem_err;
  wire drv_edge = drv_irq && !irq_q;

  assign mem_req   = (st == S_DESC_A) || (st == S_DESC_B) || (st == S_MOVE && drv_req);
  assign mem_we    = (st == S_MOVE) && dir;
  assign mem_addr  = 32'((st == S_DESC_A) ? cur_ptr :
                         (st == S_DESC_B) ? cur_ptr + AW'(4) : buf_addr);
  assign mem_wdata = drv_rdata;
  assign drv_wdata = mem_rdata[15:0];
  assign drv_ack   = (st == S_MOVE) && drv_req;
  assign irq       = int_f;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {28'b0, dir, 2'b0, run};
      3'd2:    reg_rdata = {29'b0, int_f, err_f, active};
      3'd4:    reg_rdata = 32'(tbl_ptr);
      default: reg_rdata = 32'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  run <= 1'b0;  dir <= 1'b0;  active <= 1'b0;
      err_f <= 1'b0; int_f <= 1'b0; eot <= 1'b0; irq_q <= 1'b0;
      tbl_ptr <= '0; cur_ptr <= '0; buf_addr <= '0; left <= '0;
    end else begin
      irq_q <= drv_irq;
      if (wr_cmd) begin
        run <= reg_wdata[0];
        if (!active) dir <= reg_wdata[3];
      end
      if (wr_ptr) tbl_ptr <= {reg_wdata[AW-1:2], 2'b00};
      if (drv_edge && run)               int_f <= 1'b1;
      else if (wr_sts && reg_wdata[2])   int_f <= 1'b0;
      if (fault)                         err_f <= 1'b1;
      else if (wr_sts && reg_wdata[1])   err_f <= 1'b0;

      if (halt) begin
        st <= S_IDLE; active <= 1'b0;
      end else if (go) begin
        st <= S_DESC_A; cur_ptr <= tbl_ptr; active <= 1'b1;
      end else if (fault) begin
        st <= S_IDLE; active <= 1'b0;
      end else if (mem_ack) begin
        case (st)
          S_DESC_A: begin
            buf_addr <= {mem_rdata[AW-1:1], 1'b0};
            st <= S_DESC_B;
          end
          S_DESC_B: begin
            left <= (mem_rdata[15:1] == 15'd0) ? FULL : {1'b0, mem_rdata[15:1], 1'b0};
            eot  <= mem_rdata[31];
            st   <= S_MOVE;
          end
          S_MOVE: begin
            buf_addr <= buf_addr + AW'(2);
            left     <= left - CW'(2);
            if (left == CW'(2)) begin
              if (eot) begin
                st <= S_DONE; active <= 1'b0;
              end else begin
                cur_ptr <= cur_ptr + AW'(8);
                st <= S_DESC_A;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_req_needs_active_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> active);
  assert_fault_stops_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!active && !mem_req));
  assert_even_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_addr[0]);
  assert_dir_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(dir));
  assert_int_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_f) |-> $past(drv_irq));
  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DONE) |-> (!drv_ack && !mem_req));
endmodule

// File: tb/ide_bm_dma_bench.sv
module ide_bm_dma_bench;
  timeunit 1ns; timeprecision 1ps;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  wire  [31:0] reg_rdata;
  wire         mem_req, mem_we;
  wire  [31:0] mem_addr;
  wire  [15:0] mem_wdata;
  logic [31:0] mem_rdata = 32'd0;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic        drv_req = 1'b0;
  wire         drv_ack;
  logic [15:0] drv_rdata = 16'd0;
  wire  [15:0] drv_wdata;
  logic        drv_irq = 1'b0;
  wire         irq;

  ide_bm_dma u_ide_bm_dma (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .drv_req(drv_req), .drv_ack(drv_ack), .drv_rdata(drv_rdata),
    .drv_wdata(drv_wdata), .drv_irq(drv_irq), .irq(irq)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [15:0] mem [0:1023];
  int drv_left = 0, drv_idx = 0, data_ops = 0, desc_fetches = 0, resp_cnt = 0, rx_bad = 0;
  int idx = 0;
  logic [31:0] last_desc = 0, err_addr = 32'hFFFF_FFFF, log0 = 0, log1 = 0;
  logic [15:0] seed = 16'd0;
  bit was_data = 1'b0, was_we = 1'b0;

  function automatic logic [15:0] pat(int k);
    return seed ^ 16'(k * 263) ^ 16'h5A3C;
  endfunction

  always @(negedge clk) begin
    if (mem_ack || mem_err) begin
      mem_ack = 1'b0; mem_err = 1'b0;
      if (was_data) begin
        if (!was_we && drv_wdata != pat(drv_idx)) rx_bad++;
        drv_idx++;
        if (drv_left > 0) drv_left--;
      end
    end else if (mem_req) begin
      if (resp_cnt == 0) log0 = mem_addr;
      if (resp_cnt == 1) log1 = mem_addr;
      resp_cnt++;
      if (mem_addr == err_addr) begin
        mem_err = 1'b1; was_data = 1'b0;
      end else begin
        mem_ack = 1'b1;
        idx = int'((mem_addr >> 1) & 32'h3FF);
        if (mem_addr >= 32'h400) begin
          was_data = 1'b1; was_we = mem_we; data_ops++;
          if (mem_we) mem[idx] = mem_wdata;
          else mem_rdata = {16'h0, mem[idx]};
        end else begin
          was_data = 1'b0; desc_fetches++; last_desc = mem_addr;
          mem_rdata = {mem[idx+1], mem[idx]};
        end
      end
    end
    drv_rdata = pat(drv_idx);
    drv_req = drv_left > 0;
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic put_desc(input int i, input logic [31:0] baddr, input logic [15:0] cnt, input bit last);
    int b;
    b = 32'h80 + i * 4;
    mem[b] = baddr[15:0]; mem[b+1] = baddr[31:16];
    mem[b+2] = cnt; mem[b+3] = last ? 16'h8000 : 16'h0000;
  endtask

  task automatic prep(input int words);
    resp_cnt = 0; data_ops = 0; desc_fetches = 0; drv_idx = 0; rx_bad = 0; drv_left = words;
  endtask

  task automatic pulse_irq();
    @(negedge clk); drv_irq = 1'b1;
    @(negedge clk); drv_irq = 1'b0;
  endtask

  task automatic wait_drive(input int limit);
    for (int t = 0; t < limit && drv_left > 0; t++) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  task automatic sweep_run(input int n, input int cb, input bit dir);
    logic [31:0] s;
    int k, bad;
    seed = 16'(n * 97 + cb * 13 + int'(dir));
    k = 0;
    for (int i = 0; i < n; i++) begin
      put_desc(i, 32'h400 + i * 32'h80, 16'(cb + 2 * i), i == n - 1);
      for (int w = 0; w < (cb + 2 * i) / 2; w++) begin
        mem[32'h200 + i * 32'h40 + w] = dir ? 16'hDEAD : pat(k);
        k++;
      end
    end
    prep(k);
    wr(3'd4, 32'h100);
    wr(3'd0, dir ? 32'h9 : 32'h1);
    wait_drive(2000);
    rd(3'd2, s); chk("R7 chain end clears active without interrupt", s, 32'h0);
    chk("R3 words moved", data_ops, k);
    chk("R5 descriptor reads", desc_fetches, 2 * n);
    chk("R5 last descriptor address", last_desc, 32'h100 + 8 * (n - 1) + 4);
    chk("R2 first fetch at pointer", log0, 32'h100);
    chk("R2 second fetch at pointer+4", log1, 32'h104);
    if (dir) begin
      bad = 0; k = 0;
      for (int i = 0; i < n; i++)
        for (int w = 0; w < (cb + 2 * i) / 2; w++) begin
          if (mem[32'h200 + i * 32'h40 + w] != pat(k)) bad++;
          k++;
        end
      chk("R4 memory holds drive words", bad, 0);
    end else begin
      chk("R4 drive received memory words", rx_bad, 0);
    end
    pulse_irq();
    rd(3'd2, s); chk("R8 drive interrupt sets flag", s, 32'h4);
    chk("R8 irq output", irq, 1);
    wr(3'd2, 32'h0);
    rd(3'd2, s); chk("R9 zero write leaves flag", s, 32'h4);
    wr(3'd2, 32'h4);
    rd(3'd2, s); chk("R9 write one clears interrupt", s, 32'h0);
    wr(3'd0, 32'h0);
  endtask

  initial begin
    logic [31:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd0, s); chk("R1 command reset", s, 0);
    rd(3'd2, s); chk("R1 status reset", s, 0);
    rd(3'd4, s); chk("R1 pointer reset", s, 0);
    chk("R1 no request after reset", mem_req, 0);
    wr(3'd4, 32'h0000_0103);
    rd(3'd4, s); chk("R1 pointer low bits forced to zero", s, 32'h100);

    for (int n = 1; n <= 3; n++)
      for (int cb = 2; cb <= 8; cb += 2)
        for (int d = 0; d < 2; d++)
          sweep_run(n, cb, d[0]);

    // R6: count field 0
    seed = 16'h1111;
    put_desc(0, 32'h400, 16'h0, 1'b1);
    prep(32768);
    wr(3'd0, 32'h9);
    wait_drive(70000);
    chk("R6 zero count moves 32768 words", data_ops, 32768);
    rd(3'd2, s); chk("R6 zero count completes", s, 0);
    wr(3'd0, 32'h0);

    // R8: drive ends early
    seed = 16'h2222;
    put_desc(0, 32'h400, 16'd16, 1'b1);
    prep(3);
    wr(3'd0, 32'h9);
    wait_drive(2000);
    pulse_irq();
    rd(3'd2, s); chk("R8 early end keeps active, sets interrupt", s, 32'h5);
    chk("R8 words moved before early end", data_ops, 3);
    wr(3'd0, 32'h0);
    rd(3'd2, s); chk("R12 stop clears active", s, 32'h4);
    repeat (4) @(negedge clk);
    chk("R12 no request after stop", mem_req, 0);
    wr(3'd2, 32'h4);

    // R7: chain exhausted while drive still requests
    seed = 16'h3333;
    put_desc(0, 32'h400, 16'd8, 1'b1);
    prep(6);
    wr(3'd0, 32'h9);
    for (int t = 0; t < 2000 && data_ops < 4; t++) @(negedge clk);
    repeat (10) @(negedge clk);
    rd(3'd2, s); chk("R7 exhausted chain: inactive, no interrupt", s, 0);
    chk("R7 no drive acknowledge after chain end", drv_ack, 0);
    chk("R7 no extra words", data_ops, 4);
    chk("R7 drive still waiting", drv_left, 2);
    pulse_irq();
    rd(3'd2, s); chk("R8 interrupt after exhausted chain", s, 32'h4);
    wr(3'd2, 32'h4);
    wr(3'd0, 32'h0);

    // R11: memory error on second descriptor read
    put_desc(0, 32'h400, 16'd8, 1'b1);
    err_addr = 32'h104;
    prep(4);
    wr(3'd0, 32'h9);
    repeat (20) @(negedge clk);
    rd(3'd2, s); chk("R11 error set, active cleared", s, 32'h2);
    chk("R11 no access after error", resp_cnt, 2);
    chk("R11 request low after error", mem_req, 0);
    wr(3'd2, 32'h2);
    rd(3'd2, s); chk("R9 write one clears error", s, 0);
    err_addr = 32'hFFFF_FFFF;
    wr(3'd0, 32'h0);

    // R10 / R12: direction locked while active, restart from pointer
    put_desc(0, 32'h400, 16'd4, 1'b1);
    prep(0);
    wr(3'd0, 32'h9);
    repeat (10) @(negedge clk);
    rd(3'd2, s); chk("R2 active while waiting on drive", s, 32'h1);
    wr(3'd0, 32'h1);
    rd(3'd0, s); chk("R10 direction held while active", s, 32'h9);
    wr(3'd0, 32'h0);
    rd(3'd0, s); chk("R10 direction held on stop write", s, 32'h8);
    wr(3'd0, 32'h0);
    rd(3'd0, s); chk("R10 direction written while idle", s, 32'h0);
    prep(0);
    wr(3'd0, 32'h1);
    repeat (10) @(negedge clk);
    chk("R12 restart first fetch at pointer", log0, 32'h100);
    chk("R12 restart second fetch", log1, 32'h104);
    chk("R12 restart descriptor reads", desc_fetches, 2);
    wr(3'd0, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1900000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule